// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the register side effects of taking an exception in a processor core. When the core presents an accepted exception, together with its class, a 5-bit cause code, the program counter of the faulting instruction and the current status word, the block computes the new contents of the status, saved-status, break-saved-status, cause, TLB-miss-control, exception-return and break-return registers. It also computes the redirected program counter. All of these values commit together on a single clock edge.

What gets saved depends on the exception class and on the exception-handling (EH) bit of the incoming status. A TLB miss taken while EH is clear goes to a dedicated fast-miss vector. A miss taken while EH is already set is treated as a double miss and goes to the general vector without overwriting the saved state. Break exceptions use their own pair of save registers. Both vector addresses are parameters.

Top module: `exc_entry_ctl`

## Requirements
- R1: On an accepted exception the next `status_o` equals `status_i` with PIE (bit 0) and U (bit 1) cleared. Class 0 (interrupt) additionally sets IH (bit 3), and every other defined class sets EH (bit 2). All outputs update on the clock edge that samples `exc_valid_i` high, and `redir_o` is high for exactly that one following cycle.
- R2: The cause code is written into bits [6:2] of `cause_o`, and all other bits of `cause_o` keep their previous value.
- R3: Class 0 (interrupt) copies `status_i` into `estatus_o`, sets `ea_o` to `pc_i`+4 and sets `pc_o` to GEN_VEC.
- R4: Class 1 (TLB miss) with EH clear is a fast miss. It copies `status_i` into `estatus_o`, sets `ea_o` to `pc_i`+4, clears `tlbmisc_o` bit 2 (double-miss flag), sets `tlbmisc_o` bit 3 (write-pending flag) and sets `pc_o` to FAST_VEC.
- R5: Class 1 with EH set is a double miss. It leaves `estatus_o` and `ea_o` unchanged, sets `tlbmisc_o` bit 2 and sets `pc_o` to GEN_VEC.
- R6: Class 2 (permission fault) always copies `status_i` into `estatus_o`, sets `ea_o` to `pc_i`+4 and sets `pc_o` to GEN_VEC.
- R7: Class 3 (supervisor-only) and class 4 (trap or illegal instruction) save `estatus_o` and `ea_o` (`pc_i`+4) only when EH was clear. They always set `pc_o` to GEN_VEC.
- R8: Class 5 (break) saves `status_i` into `bstatus_o` and `pc_i`+4 into `ba_o`, and only when EH was clear. It never touches `estatus_o` or `ea_o`, and sets `pc_o` to GEN_VEC.
- R9: Class codes 6 and 7 set `err_o`, which stays set until reset. They leave every register output unchanged and keep `redir_o` low.
- R10: While `exc_valid_i` is low every register output holds its value and `redir_o` stays low.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception accepted this cycle |
| exc_class_i | input | 3 | Exception class code |
| exc_code_i | input | 5 | Cause code to record |
| pc_i | input | DATA_W | PC of the excepting instruction |
| status_i | input | DATA_W | Current status word |
| status_o | output | DATA_W | Status after entry |
| estatus_o | output | DATA_W | Saved status |
| bstatus_o | output | DATA_W | Break-saved status |
| cause_o | output | DATA_W | Exception cause register |
| tlbmisc_o | output | DATA_W | TLB miss control register |
| ea_o | output | DATA_W | Exception return address |
| ba_o | output | DATA_W | Break return address |
| pc_o | output | DATA_W | Redirected program counter |
| redir_o | output | 1 | Redirect pulse |
| err_o | output | 1 | Sticky invalid-class flag |

## Verification
A wrong save decision or a wrong vector choice appears at the register outputs one cycle after the strobe. Because the bench model is compared on every clock, such a fault is caught at once. A save register that is overwritten when it should have been kept, for example on a double miss or a nested break, also shows one cycle later as a mismatch against the value held from an earlier exception. Because the sticky error flag and the held registers are compared on every idle cycle, an unintended update is also seen without delay.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    CLS_IRQ   = 3'd0,
    CLS_MISS  = 3'd1,
    CLS_PERM  = 3'd2,
    CLS_SUPER = 3'd3,
    CLS_TRAP  = 3'd4,
    CLS_BRK   = 3'd5
  } exc_class_e;

  localparam int ST_PIE  = 0;
  localparam int ST_U    = 1;
  localparam int ST_EH   = 2;
  localparam int ST_IH   = 3;
  localparam int TM_DBL  = 2;
  localparam int TM_WR   = 3;
  localparam int CODE_W  = 5;
  localparam int CODE_LO = 2;

  typedef struct packed {
    logic ok;
    logic save_e;
    logic save_b;
    logic set_ih;
    logic set_eh;
    logic tm_fast;
    logic tm_dbl;
    logic fast_vec;
  } exc_ctl_t;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_entry_pkg::*;
(
  input  logic [2:0] class_i,
  input  logic       eh_i,
  output exc_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    ctl_o.ok = 1'b1;
    ctl_o.set_eh = 1'b1;
    case (class_i)
      CLS_IRQ: begin
        ctl_o.set_eh = 1'b0;
        ctl_o.set_ih = 1'b1;
        ctl_o.save_e = 1'b1;
      end
      CLS_MISS: begin
        ctl_o.save_e   = !eh_i;
        ctl_o.tm_fast  = !eh_i;
        ctl_o.fast_vec = !eh_i;
        ctl_o.tm_dbl   = eh_i;
      end
      CLS_PERM:             ctl_o.save_e = 1'b1;
      CLS_SUPER, CLS_TRAP:  ctl_o.save_e = !eh_i;
      CLS_BRK:              ctl_o.save_b = !eh_i;
      default: begin
        ctl_o.ok     = 1'b0;
        ctl_o.set_eh = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/exc_next.sv
module exc_next
  import exc_entry_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] GEN_VEC  = 32'h0000_0120,
  parameter logic [DATA_W-1:0] FAST_VEC = 32'h0000_0200
) (
  input  exc_ctl_t           ctl_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [DATA_W-1:0]  pc_i,
  input  logic [DATA_W-1:0]  status_i,
  input  logic [DATA_W-1:0]  estatus_q,
  input  logic [DATA_W-1:0]  bstatus_q,
  input  logic [DATA_W-1:0]  cause_q,
  input  logic [DATA_W-1:0]  tlbmisc_q,
  input  logic [DATA_W-1:0]  ea_q,
  input  logic [DATA_W-1:0]  ba_q,
  output logic [DATA_W-1:0]  status_d,
  output logic [DATA_W-1:0]  estatus_d,
  output logic [DATA_W-1:0]  bstatus_d,
  output logic [DATA_W-1:0]  cause_d,
  output logic [DATA_W-1:0]  tlbmisc_d,
  output logic [DATA_W-1:0]  ea_d,
  output logic [DATA_W-1:0]  ba_d,
  output logic [DATA_W-1:0]  pc_d
);
  localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(4);
  logic [DATA_W-1:0] ret_addr;

  assign ret_addr = pc_i + PC_STEP;

  always_comb begin
    status_d = status_i;
    status_d[ST_IH]  = status_i[ST_IH] | ctl_i.set_ih;
    status_d[ST_EH]  = status_i[ST_EH] | ctl_i.set_eh;
    status_d[ST_PIE] = 1'b0;
    status_d[ST_U]   = 1'b0;
  end

  always_comb begin
    cause_d = cause_q;
    cause_d[CODE_LO +: CODE_W] = code_i;
  end

  always_comb begin
    tlbmisc_d = tlbmisc_q;
    if (ctl_i.tm_fast) begin
      tlbmisc_d[TM_DBL] = 1'b0;
      tlbmisc_d[TM_WR]  = 1'b1;
    end else if (ctl_i.tm_dbl) begin
      tlbmisc_d[TM_DBL] = 1'b1;
    end
  end

  assign estatus_d = ctl_i.save_e ? status_i : estatus_q;
  assign ea_d      = ctl_i.save_e ? ret_addr : ea_q;
  assign bstatus_d = ctl_i.save_b ? status_i : bstatus_q;
  assign ba_d      = ctl_i.save_b ? ret_addr : ba_q;
  assign pc_d      = ctl_i.fast_vec ? FAST_VEC : GEN_VEC;
endmodule

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
  import exc_entry_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] GEN_VEC  = 32'h0000_0120,
  parameter logic [DATA_W-1:0] FAST_VEC = 32'h0000_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [2:0]        exc_class_i,
  input  logic [4:0]        exc_code_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] estatus_o,
  output logic [DATA_W-1:0] bstatus_o,
  output logic [DATA_W-1:0] cause_o,
  output logic [DATA_W-1:0] tlbmisc_o,
  output logic [DATA_W-1:0] ea_o,
  output logic [DATA_W-1:0] ba_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              redir_o,
  output logic              err_o
);
  exc_ctl_t ctl;
  logic [DATA_W-1:0] status_d, estatus_d, bstatus_d, cause_d;
  logic [DATA_W-1:0] tlbmisc_d, ea_d, ba_d, pc_d;
  logic commit;

  exc_decode u_dec (
    .class_i (exc_class_i),
    .eh_i    (status_i[ST_EH]),
    .ctl_o   (ctl)
  );

  exc_next #(
    .DATA_W   (DATA_W),
    .GEN_VEC  (GEN_VEC),
    .FAST_VEC (FAST_VEC)
  ) u_next (
    .ctl_i     (ctl),
    .code_i    (exc_code_i),
    .pc_i      (pc_i),
    .status_i  (status_i),
    .estatus_q (estatus_o),
    .bstatus_q (bstatus_o),
    .cause_q   (cause_o),
    .tlbmisc_q (tlbmisc_o),
    .ea_q      (ea_o),
    .ba_q      (ba_o),
    .status_d  (status_d),
    .estatus_d (estatus_d),
    .bstatus_d (bstatus_d),
    .cause_d   (cause_d),
    .tlbmisc_d (tlbmisc_d),
    .ea_d      (ea_d),
    .ba_d      (ba_d),
    .pc_d      (pc_d)
  );

  assign commit = exc_valid_i && ctl.ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o  <= '0;
      estatus_o <= '0;
      bstatus_o <= '0;
      cause_o   <= '0;
      tlbmisc_o <= '0;
      ea_o      <= '0;
      ba_o      <= '0;
      pc_o      <= '0;
      redir_o   <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      redir_o <= commit;
      if (exc_valid_i && !ctl.ok) err_o <= 1'b1;
      if (commit) begin
        status_o  <= status_d;
        estatus_o <= estatus_d;
        bstatus_o <= bstatus_d;
        cause_o   <= cause_d;
        tlbmisc_o <= tlbmisc_d;
        ea_o      <= ea_d;
        ba_o      <= ba_d;
        pc_o      <= pc_d;
      end
    end
  end

  // R1
  pie_u_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |-> !status_o[ST_PIE] && !status_o[ST_U]);

  // R2
  cause_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> cause_o[1:0] == $past(cause_o[1:0]) &&
                    cause_o[DATA_W-1:7] == $past(cause_o[DATA_W-1:7]));

  // R5
  dbl_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && exc_class_i == CLS_MISS && status_i[ST_EH]
      |=> $stable(estatus_o) && $stable(ea_o) && tlbmisc_o[TM_DBL] && pc_o == GEN_VEC);

  // R8
  brk_no_ea_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && exc_class_i == CLS_BRK |=> $stable(estatus_o) && $stable(ea_o));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R9
  bad_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && exc_class_i > 3'd5 |=> err_o && !redir_o && $stable(status_o) && $stable(pc_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_valid_i |=> !redir_o && $stable(ea_o) && $stable(ba_o) && $stable(tlbmisc_o));
endmodule

// File: tb/sim_exc_entry_ctl.sv
module sim_exc_entry_ctl;
  localparam int W = 32;
  localparam logic [W-1:0] GV = 32'h0000_0120;
  localparam logic [W-1:0] FV = 32'h0000_0200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [2:0] cls = '0;
  logic [4:0] code = '0;
  logic [W-1:0] pc = '0, st = '0;
  logic [W-1:0] status_o, estatus_o, bstatus_o, cause_o, tlbmisc_o, ea_o, ba_o, pc_o;
  logic redir_o, err_o;

  always #2.5 clk = ~clk;

  exc_entry_ctl #(.DATA_W(W), .GEN_VEC(GV), .FAST_VEC(FV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(vld), .exc_class_i(cls),
    .exc_code_i(code), .pc_i(pc), .status_i(st),
    .status_o(status_o), .estatus_o(estatus_o), .bstatus_o(bstatus_o),
    .cause_o(cause_o), .tlbmisc_o(tlbmisc_o), .ea_o(ea_o), .ba_o(ba_o),
    .pc_o(pc_o), .redir_o(redir_o), .err_o(err_o));

  // reference model
  logic [W-1:0] m_st, m_es, m_bs, m_ca, m_tm, m_ea, m_ba, m_pc;
  logic m_rd, m_er;
  string tag = "R11";
  int checks = 0, fails = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_es = 0; m_bs = 0; m_ca = 0; m_tm = 0;
      m_ea = 0; m_ba = 0; m_pc = 0; m_rd = 0; m_er = 0; tag = "R11";
    end else begin
      m_rd = 0;
      if (!vld) tag = "R10";
      else if (cls > 5) begin m_er = 1; tag = "R9"; end
      else begin
        bit eh;
        eh = st[2];
        m_rd = 1;
        m_ca = (m_ca & ~(32'h1f << 2)) | (W'(code) << 2);
        m_pc = GV;
        case (cls)
          0: begin tag = "R3"; m_es = st; m_ea = pc + 4; end
          1: if (!eh) begin
               tag = "R4"; m_es = st; m_ea = pc + 4; m_pc = FV;
               m_tm = (m_tm & ~32'h4) | 32'h8;
             end else begin tag = "R5"; m_tm = m_tm | 32'h4; end
          2: begin tag = "R6"; m_es = st; m_ea = pc + 4; end
          3, 4: begin tag = "R7"; if (!eh) begin m_es = st; m_ea = pc + 4; end end
          default: begin tag = "R8"; if (!eh) begin m_bs = st; m_ba = pc + 4; end end
        endcase
        m_st = st & ~32'h3;
        if (cls == 0) m_st = m_st | 32'h8; else m_st = m_st | 32'h4;
      end
    end
  end

  task automatic chk(string t, string n, logic [W-1:0] a, logic [W-1:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", t, n, a, e);
    end
  endtask

  always @(negedge clk) begin
    chk("R1", "status", status_o, m_st);
    chk("R2", "cause", cause_o, m_ca);
    chk(tag, "estatus", estatus_o, m_es);
    chk(tag, "bstatus", bstatus_o, m_bs);
    chk(tag, "tlbmisc", tlbmisc_o, m_tm);
    chk(tag, "ea", ea_o, m_ea);
    chk(tag, "ba", ba_o, m_ba);
    chk(tag, "pc", pc_o, m_pc);
    chk("R1", "redir", W'(redir_o), W'(m_rd));
    chk("R9", "err", W'(err_o), W'(m_er));
  end

  task automatic fire(input logic [2:0] c, input logic [4:0] k,
                      input logic [W-1:0] p, input logic [W-1:0] s);
    @(negedge clk);
    vld = 1; cls = c; code = k; pc = p; st = s;
    @(negedge clk);
    vld = 0; cls = $urandom; code = $urandom; pc = $urandom; st = $urandom;
  endtask

  logic done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fire(0, 5'd11, 32'h1000, 32'h0000_0003);   // R3
    fire(1, 5'd12, 32'h2000, 32'h0000_0001);   // R4 fast
    fire(1, 5'd12, 32'h2100, 32'h0000_0005);   // R5 double
    fire(2, 5'd13, 32'h3000, 32'h0000_0004);   // R6 with EH set
    fire(3, 5'd9,  32'h4000, 32'h0000_0002);   // R7 EH clear
    fire(4, 5'd3,  32'h4100, 32'hf000_0006);   // R7 EH set
    fire(5, 5'd7,  32'h5000, 32'h0000_0001);   // R8 EH clear
    fire(5, 5'd7,  32'h5100, 32'h0000_0004);   // R8 EH set
    fire(1, 5'd12, 32'h2200, 32'h0000_0000);   // R4 clears DBL
    fire(6, 5'd31, 32'h6000, 32'h0000_0000);   // R9
    fire(7, 5'd30, 32'h6100, 32'h0000_0000);   // R9
    fire(0, 5'd31, 32'hffff_fffc, 32'hffff_ffff); // R3 wrap
    repeat (4) @(negedge clk);                 // R10
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      vld = $urandom_range(0, 1); cls = $urandom_range(0, 5);
      code = $urandom; pc = $urandom; st = $urandom;
    end
    @(negedge clk); vld = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule